// File: doc/BRIEF.md
# SRAM Checkerboard March Self-Test Controller

This block is a synchronous self-test engine for a 2048 x 8 static RAM that has active-low select, write and output-enable strobes. A single start pulse launches a fixed test. First, an ascending fill pass writes an alternating byte pattern. Next, a descending pass reads each word and then overwrites it with the complementary byte. An ascending pass then reads the complement back. Finally, a per-bit data-line check runs at address zero, in which each data bit in turn is written low, read, written high and read, with only that bit compared.

The controller drives the address, the write data and the three strobes from registers. The RAM is assumed to present read data one clock after it samples a read strobe. Each access takes two cycles: a strobe cycle, then a recovery cycle with idle strobes, during which the returned byte is compared. The first mismatch is captured with its address, the expected byte and the observed byte. The run always goes to completion. A one-cycle done pulse closes the run, and the status holds until the next start.

Top module: `sram_march_bist`

## Requirements
- R1: Fill pass: accesses 0..2047 are writes at ascending addresses 0x000..0x7FF, each carrying 0xAA at an even address and 0x55 at an odd address.
- R2: Descending pass: from 0x7FF down to 0x000, each address gets a read that expects the fill value, followed by a write of its complement (0x55 at even, 0xAA at odd).
- R3: Verify pass: reads at ascending addresses 0x000..0x7FF, expecting 0x55 at even and 0xAA at odd addresses.
- R4: Data-line pass: for bit b = 0..7 in order, at address 0x000: write 0x00, read, write (1<<b), read. Only bit b of each read is compared, and the expected byte reported is the byte written.
- R5: A write strobe cycle has mem_we_n=0, mem_cs_n=0, mem_oe_n=1 and data on mem_wdata. A read strobe cycle has mem_we_n=1, mem_cs_n=0, mem_oe_n=0. Every strobe cycle is followed by one idle cycle (we_n=1, cs_n=0, oe_n=0) at the same address. The read byte is sampled at the end of that idle cycle.
- R6: mem_we_n and mem_oe_n are never low together, and while mem_cs_n is high both are high.
- R7: On the first mismatch, fail rises and fail_addr, fail_exp and fail_obs capture that access. Later mismatches leave them unchanged.
- R8: done pulses for exactly one cycle, 16449 cycles after the clock edge that accepts start. While done is high mem_oe_n is high, and it stays high until the next start. The status holds after done.
- R9: A start while a run is in progress is ignored. A start after completion clears the status and repeats the whole test.
- R10: After reset, all three strobes are high, and done, fail and the captured fields are zero.
- R11: A fault-free RAM gives fail=0 at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| mem_addr | output | 11 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the read strobe |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | A mismatch has been seen |
| fail_addr | output | 11 | Address of the first mismatch |
| fail_exp | output | 8 | Expected byte of the first mismatch |
| fail_obs | output | 8 | Observed byte of the first mismatch |

## Verification
The hardest case to reach from the ports is a fault that only the masked data-line compare can catch, while faults on other bits of the same byte must be ignored. The bench model arms a fault on address zero only after the march passes have finished. The fault forces bit 5 low and bit 6 high on reads. As a result, reads with bit 0 through bit 4 under test must pass, and the first capture must come from the read of bit 5 written high. A second run places a stuck bit on one mid-array cell and pulses start in the middle of the run. That run shows that the first capture comes from the descending pass, that later passes do not overwrite it, and that the completion time does not move.

// File: rtl/sram_march_pkg.sv
package sram_march_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_FILL,
    PS_DOWN,
    PS_VERIFY,
    PS_DLINE,
    PS_END
  } pass_e;

  typedef enum logic [1:0] {
    AK_NONE,
    AK_WRITE,
    AK_READ
  } acc_e;

endpackage

// File: rtl/march_seq.sv
module march_seq
  import sram_march_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  output pass_e             pass_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        sub_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic              ph_q
);

  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(DATA_W - 1);

  pass_e             pass_n;
  logic [ADDR_W-1:0] addr_n;
  logic [1:0]        sub_n;
  logic [BIT_W-1:0]  bit_n;
  logic              ph_n;
  logic              running;

  assign running = (pass_q == PS_FILL) || (pass_q == PS_DOWN) ||
                   (pass_q == PS_VERIFY) || (pass_q == PS_DLINE);

  always_comb begin
    pass_n = pass_q;
    addr_n = addr_q;
    sub_n  = sub_q;
    bit_n  = bit_q;
    ph_n   = ph_q;
    if (launch) begin
      pass_n = PS_FILL;
      addr_n = '0;
      sub_n  = '0;
      bit_n  = '0;
      ph_n   = 1'b0;
    end else if (running) begin
      ph_n = ~ph_q;
      if (ph_q) begin
        case (pass_q)
          PS_FILL: begin
            if (addr_q == ADDR_LAST) begin
              pass_n = PS_DOWN;
              sub_n  = 2'd0;
            end else begin
              addr_n = addr_q + 1'b1;
            end
          end
          PS_DOWN: begin
            if (sub_q == 2'd0) begin
              sub_n = 2'd1;
            end else begin
              sub_n = 2'd0;
              if (addr_q == '0) pass_n = PS_VERIFY;
              else              addr_n = addr_q - 1'b1;
            end
          end
          PS_VERIFY: begin
            if (addr_q == ADDR_LAST) begin
              pass_n = PS_DLINE;
              addr_n = '0;
              sub_n  = 2'd0;
              bit_n  = '0;
            end else begin
              addr_n = addr_q + 1'b1;
            end
          end
          PS_DLINE: begin
            if (sub_q == 2'd3) begin
              sub_n = 2'd0;
              if (bit_q == BIT_LAST) pass_n = PS_END;
              else                   bit_n  = bit_q + 1'b1;
            end else begin
              sub_n = sub_q + 2'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= PS_IDLE;
      addr_q <= '0;
      sub_q  <= '0;
      bit_q  <= '0;
      ph_q   <= 1'b0;
    end else begin
      pass_q <= pass_n;
      addr_q <= addr_n;
      sub_q  <= sub_n;
      bit_q  <= bit_n;
      ph_q   <= ph_n;
    end
  end

endmodule

// File: rtl/march_decode.sv
module march_decode
  import sram_march_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  pass_e             pass_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        sub_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              ph_i,
  output acc_e              kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] exp_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              cs_n_o,
  output logic              we_n_o,
  output logic              oe_n_o
);

  localparam logic [DATA_W-1:0] PAT_EVEN = {(DATA_W/2){2'b10}};
  localparam logic [DATA_W-1:0] PAT_ODD  = ~PAT_EVEN;

  logic [DATA_W-1:0] pat;
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] wbyte;

  always_comb begin
    pat    = addr_i[0] ? PAT_ODD : PAT_EVEN;
    sel    = DATA_W'(1) << bit_i;
    kind_o = AK_NONE;
    addr_o = addr_i;
    wbyte  = '0;
    exp_o  = '0;
    mask_o = '1;
    cs_n_o = 1'b1;
    we_n_o = 1'b1;
    oe_n_o = 1'b1;
    case (pass_i)
      PS_END:  cs_n_o = 1'b0;
      PS_FILL: begin
        kind_o = AK_WRITE;
        wbyte  = pat;
      end
      PS_DOWN: begin
        if (sub_i[0]) begin
          kind_o = AK_WRITE;
          wbyte  = ~pat;
        end else begin
          kind_o = AK_READ;
          exp_o  = pat;
        end
      end
      PS_VERIFY: begin
        kind_o = AK_READ;
        exp_o  = ~pat;
      end
      PS_DLINE: begin
        addr_o = '0;
        mask_o = sel;
        kind_o = sub_i[0] ? AK_READ : AK_WRITE;
        wbyte  = sub_i[1] ? sel : '0;
        exp_o  = wbyte;
      end
      default: ;
    endcase
    if (kind_o != AK_NONE) begin
      cs_n_o = 1'b0;
      if (kind_o == AK_WRITE && !ph_i) begin
        we_n_o = 1'b0;
        oe_n_o = 1'b1;
      end else begin
        we_n_o = 1'b1;
        oe_n_o = 1'b0;
      end
    end
    wdata_o = (kind_o == AK_WRITE && !ph_i) ? wbyte : '0;
  end

endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] exp,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] exp_q,
  output logic [DATA_W-1:0] obs_q
);

  logic miss;
  assign miss = |((rdata ^ exp) & mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail_q <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
      obs_q  <= '0;
    end else if (en && miss && !fail_q) begin
      fail_q <= 1'b1;
      addr_q <= addr;
      exp_q  <= exp;
      obs_q  <= rdata;
    end
  end

endmodule

// File: rtl/sram_march_bist.sv
module sram_march_bist
  import sram_march_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);

  localparam int BIT_W = $clog2(DATA_W);

  pass_e             st_pass;
  logic [ADDR_W-1:0] st_addr;
  logic [1:0]        st_sub;
  logic [BIT_W-1:0]  st_bit;
  logic              st_ph;
  logic              launch;

  acc_e              d_kind;
  logic [ADDR_W-1:0] d_addr;
  logic [DATA_W-1:0] d_wdata, d_exp, d_mask;
  logic              d_cs_n, d_we_n, d_oe_n;

  acc_e              a_kind_q;
  pass_e             a_pass_q;
  logic              a_ph_q;
  logic [DATA_W-1:0] a_exp_q, a_mask_q;
  logic              done_q;
  logic              cmp_en;

  assign launch = start &&
                  (((st_pass == PS_IDLE) && (a_pass_q == PS_IDLE)) ||
                   ((st_pass == PS_END)  && (a_pass_q == PS_END)));

  march_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .pass_q (st_pass),
    .addr_q (st_addr),
    .sub_q  (st_sub),
    .bit_q  (st_bit),
    .ph_q   (st_ph)
  );

  march_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_dec (
    .pass_i  (st_pass),
    .addr_i  (st_addr),
    .sub_i   (st_sub),
    .bit_i   (st_bit),
    .ph_i    (st_ph),
    .kind_o  (d_kind),
    .addr_o  (d_addr),
    .wdata_o (d_wdata),
    .exp_o   (d_exp),
    .mask_o  (d_mask),
    .cs_n_o  (d_cs_n),
    .we_n_o  (d_we_n),
    .oe_n_o  (d_oe_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      a_kind_q  <= AK_NONE;
      a_pass_q  <= PS_IDLE;
      a_ph_q    <= 1'b0;
      a_exp_q   <= '0;
      a_mask_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      mem_addr  <= d_addr;
      mem_wdata <= d_wdata;
      mem_cs_n  <= d_cs_n;
      mem_we_n  <= d_we_n;
      mem_oe_n  <= d_oe_n;
      a_kind_q  <= d_kind;
      a_pass_q  <= st_pass;
      a_ph_q    <= st_ph;
      a_exp_q   <= d_exp;
      a_mask_q  <= d_mask;
      done_q    <= (st_pass == PS_END) && (a_pass_q != PS_END);
    end
  end

  assign cmp_en = (a_kind_q == AK_READ) && a_ph_q;

  march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .clr    (launch),
    .en     (cmp_en),
    .addr   (mem_addr),
    .exp    (a_exp_q),
    .mask   (a_mask_q),
    .rdata  (mem_rdata),
    .fail_q (fail),
    .addr_q (fail_addr),
    .exp_q  (fail_exp),
    .obs_q  (fail_obs)
  );

  assign done = done_q;

endmodule

// File: rtl/sram_march_bist_chk.sv
module sram_march_bist_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [DATA_W-1:0] fail_exp,
  input logic [DATA_W-1:0] fail_obs
);

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n)); // R6

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_cs_n |-> (mem_we_n && mem_oe_n)); // R6

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> mem_we_n); // R5

  AST_WR_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    done |-> mem_oe_n); // R8

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail); // R7

  AST_FAIL_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_obs))); // R7

endmodule

bind sram_march_bist sram_march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_exp  (fail_exp),
  .fail_obs  (fail_obs)
);

// File: tb/sram_march_bist_tb_top.sv
`timescale 1ns/1ps
module sram_march_bist_tb_top;
  localparam int AW   = 11;
  localparam int DW   = 8;
  localparam int NW   = 1 << AW;
  localparam int NACC = 4*NW + 4*DW;
  localparam int LAT  = 2*NACC + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, fail_exp, fail_obs;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_cs_n, mem_we_n, mem_oe_n, done, fail;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  sram_march_bist #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_obs(fail_obs)
  );

  // RAM model: registered read, one cycle latency, optional read fault
  logic [DW-1:0] ram [NW];
  bit            flt_on = 0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_clr = '0, flt_set = '0;
  int            flt_from = 0;
  int            mon_idx = 0;

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) ram[mem_addr] <= mem_wdata;
    if (!mem_cs_n && mem_we_n && !mem_oe_n) begin
      if (flt_on && mem_addr == flt_addr && mon_idx >= flt_from)
        mem_rdata <= (ram[mem_addr] & ~flt_clr) | flt_set;
      else
        mem_rdata <= ram[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[0] ? 8'h55 : 8'hAA;
  endfunction

  function automatic void exp_acc(input int i, output bit wr, output logic [AW-1:0] a,
                                  output logic [DW-1:0] d, output int rq);
    if (i < NW) begin
      wr = 1; a = AW'(i); d = pat(a); rq = 1;
    end else if (i < 3*NW) begin
      int j = i - NW;
      a = AW'(NW - 1 - j/2); wr = (j % 2) == 1; d = ~pat(a); rq = 2;
    end else if (i < 4*NW) begin
      wr = 0; a = AW'(i - 3*NW); d = '0; rq = 3;
    end else begin
      int k = i - 4*NW;
      int s = k % 4;
      a = '0; wr = (s % 2) == 0;
      d = (s == 2) ? (DW'(1) << (k/4)) : '0; rq = 4;
    end
  endfunction

  // Port monitor: follows two-cycle access slots after the first write strobe
  bit            mon_arm = 0, mon_run = 0, mon_half = 0;
  int            me [7];
  logic [AW-1:0] mon_addr;
  bit            e_wr, o_wr;
  logic [AW-1:0] e_a;
  logic [DW-1:0] e_d;
  int            e_rq;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_cs_n && !(mem_we_n && mem_oe_n)) me[6]++;
      if (!mem_we_n && !mem_oe_n) me[6]++;
    end
    if (mon_arm && !mon_run && !mem_we_n) begin
      mon_run = 1; mon_half = 0;
    end
    if (mon_run) begin
      if (!mon_half) begin
        exp_acc(mon_idx, e_wr, e_a, e_d, e_rq);
        o_wr = !mem_we_n;
        if (o_wr != e_wr || mem_addr != e_a || (o_wr && mem_wdata != e_d)) me[e_rq]++;
        if (o_wr && (mem_cs_n || !mem_oe_n)) me[5]++;
        if (!o_wr && (mem_cs_n || mem_oe_n)) me[5]++;
        mon_addr = mem_addr; mon_half = 1;
      end else begin
        if (mem_we_n !== 1'b1 || mem_cs_n !== 1'b0 || mem_oe_n !== 1'b0 ||
            mem_addr != mon_addr) me[5]++;
        mon_idx++; mon_half = 0;
        if (mon_idx == NACC) begin mon_run = 0; mon_arm = 0; end
      end
    end
  end

  int  lat;
  bit  early_fail;

  task automatic run_bist(input int mid);
    mon_idx = 0; mon_arm = 1; mon_run = 0;
    for (int r = 1; r < 6; r++) me[r] = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    lat = 0;
    early_fail = 1'b1;
    while (!done && lat < LAT + 100) begin
      @(negedge clk);
      lat++;
      start = (lat == mid);
      if (lat == 2) early_fail = fail;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R10", "strobes after reset", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!done && !fail, "R10", "done/fail after reset", {done, fail}, 0);
    chk(fail_addr == 0 && fail_exp == 0 && fail_obs == 0, "R10", "fields after reset",
        {fail_addr, fail_exp, fail_obs}, 0);
  endtask

  task automatic t_clean();
    run_bist(0);
    chk(lat == LAT, "R8", "done latency", lat, LAT);
    chk(mem_oe_n, "R8", "oe_n during done", mem_oe_n, 1);
    chk(me[1] == 0, "R1", "fill pass access mismatches", me[1], 0);
    chk(me[2] == 0, "R2", "descending pass access mismatches", me[2], 0);
    chk(me[3] == 0, "R3", "verify pass access mismatches", me[3], 0);
    chk(me[4] == 0, "R4", "data-line access mismatches", me[4], 0);
    chk(me[5] == 0 && mon_idx == NACC, "R5", "strobe/idle slots", me[5], 0);
    chk(!fail, "R11", "fail on clean RAM", fail, 0);
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    repeat (3) @(negedge clk);
    chk(mem_oe_n && !done, "R8", "oe_n held after done", mem_oe_n, 1);
  endtask

  task automatic t_cell();
    flt_on = 1; flt_addr = 11'h123; flt_clr = 8'h00; flt_set = 8'h08; flt_from = 0;
    run_bist(700);
    chk(lat == LAT, "R9", "latency with mid-run start", lat, LAT);
    chk(mon_idx == NACC, "R9", "full access count with mid-run start", mon_idx, NACC);
    chk(fail, "R7", "fail on stuck cell", fail, 1);
    chk(fail_addr == 11'h123, "R2", "first fail address", fail_addr, 11'h123);
    chk(fail_exp == 8'h55 && fail_obs == 8'h5D, "R7", "captured exp/obs",
        {fail_exp, fail_obs}, 16'h555D);
    repeat (5) @(negedge clk);
    chk(fail && fail_addr == 11'h123 && fail_obs == 8'h5D, "R8", "status held after done",
        fail_obs, 8'h5D);
  endtask

  task automatic t_dline();
    flt_on = 1; flt_addr = '0; flt_clr = 8'h20; flt_set = 8'h40; flt_from = 4*NW;
    run_bist(0);
    chk(lat == LAT, "R8", "latency data-line run", lat, LAT);
    chk(fail && fail_addr == '0, "R4", "data-line fail at address zero", fail_addr, 0);
    chk(fail_exp == 8'h20, "R4", "masked compare expected byte", fail_exp, 8'h20);
    chk(fail_obs == 8'h40, "R7", "first data-line mismatch kept", fail_obs, 8'h40);
  endtask

  task automatic t_restart();
    flt_on = 0;
    chk(fail, "R9", "fail before restart", fail, 1);
    run_bist(0);
    chk(!early_fail, "R9", "status cleared by start", early_fail, 0);
    chk(!fail && lat == LAT, "R9", "rerun clean", {fail, lat}, LAT);
    chk(me[1] == 0 && me[2] == 0 && me[3] == 0, "R1", "rerun march order", me[1] + me[2] + me[3], 0);
    chk(me[6] == 0, "R6", "strobe rule violations", me[6], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int r = 0; r < 7; r++) me[r] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_cell();
    t_dline();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule